// File: doc/BRIEF.md
# Two-Channel Threshold Alarm Monitor

The block watches four measured quantities, the temperature and the drain current of two power channels. Each quantity arrives as a 12-bit unsigned code with a one-cycle strobe and a selector naming the quantity. Every new code is compared against a programmable low and high limit. The result updates a per-quantity high condition and a per-quantity low condition. It also sets the matching bits of an eight-bit flag register.

Each quantity can be enabled on its own and uses one of two comparison styles. The window style flags both limits and adds a fixed four-code release margin. The hysteresis style raises the high condition above the high limit and drops it only below the low limit. Two safe outputs (one per channel) and one global alarm output report the state. They follow either the live conditions (comparator mode) or the latched flags (interrupt mode), and each output has its own polarity. A simple register port writes limits and configuration, reads them back one cycle later, and reads the flag register. Reading the flag register clears it.

Top module: `tam_monitor`

## Requirements
- R1: After reset all high limits read 0x0FFF, all low limits and the configuration read 0, the flag register reads 0, and safe1, safe2 and alarm sit at their inactive level for the default active-low polarity (logic 1).
- R2: Register map: address 2q holds the low limit and 2q+1 the high limit of quantity q (q=0 ch1 temperature, 1 ch1 current, 2 ch2 temperature, 3 ch2 current); address 8 is configuration, address 9 a clear command, address 10 the flag register. A read returns the value in reg_rdata on the cycle after the read strobe, zero-extended; limit writes keep only bits 11:0.
- R3: Window style, high side: the high condition sets on a code strictly above the high limit and clears on a code for which code+4 is below the high limit.
- R4: Window style, low side: the low condition sets on a code strictly below the low limit and clears on a code strictly above low limit+4.
- R5: Hysteresis style: the high condition sets on a code above the high limit and clears only on a code below the low limit; the low condition never sets.
- R6: A quantity whose enable bit (configuration bit 2q) is 0 ignores its measurements, holds both conditions at 0 and raises no flag.
- R7: Flag bit 2q+1 (high) or 2q (low) sets whenever a measurement of enabled quantity q leaves that condition set; flag bits are, from bit 7 down, ch2 current high/low, ch2 temperature high/low, ch1 current high/low, ch1 temperature high/low; reading address 10 returns the flags and clears them.
- R8: When a flag read and a flag-setting measurement fall in the same cycle, the read returns the old value and the new flag bit stays set.
- R9: Writing 1 to bit 0 of address 9 clears every flag and every condition.
- R10: In comparator mode (configuration bit 8 = 0) safe1 reports whether any ch1 condition is set, safe2 any ch2 condition, and alarm the OR of both; conditions move only on a measurement, a clear or an enable change.
- R11: In interrupt mode (configuration bit 8 = 1) each output reports the OR of its channel's flag bits, so it stays asserted after the condition ends until the flag register is read.
- R12: Configuration bits 9, 10 and 11 set safe1, safe2 and alarm active-high when 1 and active-low when 0; bit 2q+1 selects window style when 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe for a new measurement |
| meas_sel | input | 2 | Quantity index q of the measurement |
| meas_code | input | 12 | Unsigned measurement code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| safe1 | output | 1 | Channel 1 safe output, programmable polarity |
| safe2 | output | 1 | Channel 2 safe output, programmable polarity |
| alarm | output | 1 | Global alarm output, programmable polarity |

## Verification
The comparison logic is driven with code sequences that walk each limit from both sides. A code equal to a limit, one code past it, and codes just inside and outside the four-code release margin separate a strict from a non-strict compare and an off-by-one margin. The same code sequences go to a hysteresis-style quantity, where a code between the limits must hold the alarm and a code under the low limit must never raise the low flag. This tells the two styles apart. Measurements to a disabled quantity, a measurement coinciding with a flag read, a clear command while a condition is live, and a polarity flip on an asserted output isolate the flag-lifetime and output-mode paths.

// File: rtl/tam_pkg.sv
package tam_pkg;
    // quantity count: two channels, each with temperature and current
    localparam int NQ      = 4;
    localparam int NCH     = 2;
    localparam int QPC     = NQ / NCH;
    localparam int FLAG_W  = 2 * NQ;
    localparam int CFG_W   = 12;

    // configuration bit positions beyond the per-quantity pairs
    localparam int CFG_INTR      = 8;
    localparam int CFG_POL_SAFE0 = 9;
    localparam int CFG_POL_ALARM = 11;

    // register addresses above the limit block
    localparam logic [3:0] ADR_CFG  = 4'd8;
    localparam logic [3:0] ADR_CLR  = 4'd9;
    localparam logic [3:0] ADR_FLAG = 4'd10;
endpackage

// File: rtl/tam_quantity_mon.sv
module tam_quantity_mon
    import tam_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int HYST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              clr,
    input  logic              en,
    input  logic              win,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] thr_lo,
    input  logic [CODE_W-1:0] thr_hi,
    output logic              hi_cond,
    output logic              lo_cond,
    output logic              hi_evt,
    output logic              lo_evt
);
    localparam int W = CODE_W + 1;

    typedef struct packed {
        logic hi;
        logic lo;
    } mon_st_t;

    mon_st_t st_d, st_q;

    logic [W-1:0] c_x, lo_x, hi_x;
    logic above, below, hi_release, lo_release;

    always_comb begin
        c_x  = {1'b0, code};
        lo_x = {1'b0, thr_lo};
        hi_x = {1'b0, thr_hi};
        above      = c_x > hi_x;
        below      = c_x < lo_x;
        hi_release = (c_x + W'(HYST)) < hi_x;
        lo_release = c_x > (lo_x + W'(HYST));

        st_d   = st_q;
        hi_evt = 1'b0;
        lo_evt = 1'b0;
        if (clr || !en) begin
            st_d = '0;
        end else if (upd) begin
            if (win) begin
                st_d.hi = st_q.hi ? !hi_release : above;
                st_d.lo = st_q.lo ? !lo_release : below;
            end else begin
                st_d.hi = st_q.hi ? !below : above;
                st_d.lo = 1'b0;
            end
            hi_evt = st_d.hi;
            lo_evt = st_d.lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_cond = st_q.hi;
    assign lo_cond = st_q.lo;
endmodule

// File: rtl/tam_reg_file.sv
module tam_reg_file
    import tam_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [FLAG_W-1:0]           flags,
    output logic [NQ-1:0][CODE_W-1:0]   thr_lo,
    output logic [NQ-1:0][CODE_W-1:0]   thr_hi,
    output logic [CFG_W-1:0]            cfg,
    output logic [DATA_W-1:0]           rdata,
    output logic                        clr_pulse,
    output logic                        flag_rd
);
    localparam int QW = $clog2(NQ);

    typedef struct packed {
        logic [NQ-1:0][CODE_W-1:0] lo;
        logic [NQ-1:0][CODE_W-1:0] hi;
        logic [CFG_W-1:0]          cfg;
        logic [DATA_W-1:0]         rdata;
    } rf_st_t;

    rf_st_t st_d, st_q;

    logic            in_limits;
    logic [QW-1:0]   qidx;
    logic [DATA_W-1:0] rd_val;
    logic            unused_bits;

    assign unused_bits = ^wdata[DATA_W-1:CFG_W];

    always_comb begin
        in_limits = (addr[ADDR_W-1:QW+1] == '0);
        qidx      = addr[QW:1];

        rd_val = '0;
        if (in_limits) begin
            rd_val[CODE_W-1:0] = addr[0] ? st_q.hi[qidx] : st_q.lo[qidx];
        end else if (addr == ADDR_W'(ADR_CFG)) begin
            rd_val[CFG_W-1:0] = st_q.cfg;
        end else if (addr == ADDR_W'(ADR_FLAG)) begin
            rd_val[FLAG_W-1:0] = flags;
        end

        st_d = st_q;
        if (rd) st_d.rdata = rd_val;
        if (wr) begin
            if (in_limits) begin
                if (addr[0]) st_d.hi[qidx] = wdata[CODE_W-1:0];
                else         st_d.lo[qidx] = wdata[CODE_W-1:0];
            end else if (addr == ADDR_W'(ADR_CFG)) begin
                st_d.cfg = wdata[CFG_W-1:0];
            end
        end

        clr_pulse = wr && (addr == ADDR_W'(ADR_CLR)) && wdata[0];
        flag_rd   = rd && (addr == ADDR_W'(ADR_FLAG));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo    <= '0;
            st_q.hi    <= '1;
            st_q.cfg   <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_lo = st_q.lo;
    assign thr_hi = st_q.hi;
    assign cfg    = st_q.cfg;
    assign rdata  = st_q.rdata;
endmodule

// File: rtl/tam_status.sv
module tam_status
    import tam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt,
    input  logic [FLAG_W-1:0] cond,
    input  logic              flag_rd,
    input  logic              clr,
    input  logic              intr,
    input  logic [NCH-1:0]    pol_safe,
    input  logic              pol_alarm,
    output logic [FLAG_W-1:0] flags,
    output logic [NCH-1:0]    safe_pin,
    output logic              alarm_pin
);
    localparam int BPC = 2 * QPC;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [NCH-1:0] ch_act;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.flags = '0;
        else     st_d.flags = (flag_rd ? '0 : st_q.flags) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_act[c]   = intr ? (|st_q.flags[c*BPC +: BPC]) : (|cond[c*BPC +: BPC]);
        assign safe_pin[c] = pol_safe[c] ? ch_act[c] : ~ch_act[c];
    end

    assign alarm_pin = pol_alarm ? (|ch_act) : ~(|ch_act);
    assign flags     = st_q.flags;
endmodule

// File: rtl/tam_monitor.sv
module tam_monitor
    import tam_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int HYST   = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic [1:0]        meas_sel,
    input  logic [CODE_W-1:0] meas_code,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              safe1,
    output logic              safe2,
    output logic              alarm
);
    logic [NQ-1:0][CODE_W-1:0] thr_lo_w, thr_hi_w;
    logic [CFG_W-1:0]          cfg_w;
    logic                      clr_w, flag_rd_w;
    logic [FLAG_W-1:0]         cond_w, evt_w, flags_w, en_mask_w;
    logic [NCH-1:0]            safe_w;
    logic                      alarm_w;

    tam_reg_file #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .flags     (flags_w),
        .thr_lo    (thr_lo_w),
        .thr_hi    (thr_hi_w),
        .cfg       (cfg_w),
        .rdata     (reg_rdata),
        .clr_pulse (clr_w),
        .flag_rd   (flag_rd_w)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        tam_quantity_mon #(.CODE_W(CODE_W), .HYST(HYST)) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (meas_valid && (meas_sel == 2'(q))),
            .clr     (clr_w),
            .en      (cfg_w[2*q]),
            .win     (cfg_w[2*q+1]),
            .code    (meas_code),
            .thr_lo  (thr_lo_w[q]),
            .thr_hi  (thr_hi_w[q]),
            .hi_cond (cond_w[2*q+1]),
            .lo_cond (cond_w[2*q]),
            .hi_evt  (evt_w[2*q+1]),
            .lo_evt  (evt_w[2*q])
        );
        assign en_mask_w[2*q+1:2*q] = {2{cfg_w[2*q]}};
    end

    tam_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_w),
        .cond      (cond_w),
        .flag_rd   (flag_rd_w),
        .clr       (clr_w),
        .intr      (cfg_w[CFG_INTR]),
        .pol_safe  (cfg_w[CFG_POL_SAFE0 +: NCH]),
        .pol_alarm (cfg_w[CFG_POL_ALARM]),
        .flags     (flags_w),
        .safe_pin  (safe_w),
        .alarm_pin (alarm_w)
    );

    assign safe1 = safe_w[0];
    assign safe2 = safe_w[1];
    assign alarm = alarm_w;
endmodule

// File: rtl/tam_monitor_chk.sv
module tam_monitor_chk
    import tam_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              meas_valid,
    input logic              reg_wr,
    input logic              flag_rd,
    input logic              clr,
    input logic [FLAG_W-1:0] evt,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] conds,
    input logic [FLAG_W-1:0] en_mask
);
    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !clr && evt == '0) |=> (flags == '0)); // R7

    AST_EVENT_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0 && !clr) |=> ((flags & $past(evt)) == $past(evt))); // R8

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0 && conds == '0)); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((conds & ~$past(en_mask)) == '0)); // R6

    AST_COND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid && !clr && !reg_wr && !$past(reg_wr)) |=> $stable(conds)); // R10
endmodule

bind tam_monitor tam_monitor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .reg_wr     (reg_wr),
    .flag_rd    (flag_rd_w),
    .clr        (clr_w),
    .evt        (evt_w),
    .flags      (flags_w),
    .conds      (cond_w),
    .en_mask    (en_mask_w)
);

// File: tb/sim_tam_monitor.sv
`timescale 1ns/1ps
module sim_tam_monitor;
    localparam time CLK_P = 20ns;
    localparam int  NVEC  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_valid = 1'b0;
    logic [1:0]  meas_sel = '0;
    logic [11:0] meas_code = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        safe1, safe2, alarm;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tam_monitor u0 (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_sel(meas_sel),
        .meas_code(meas_code), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .safe1(safe1), .safe2(safe2),
        .alarm(alarm)
    );

    // {sel[2], code[12], expected flags[8], expected {safe1,safe2}[2]}
    // limits: t1 100/200 window, i1 1000/2000 hysteresis, t2 50/60 window, i2 disabled
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd0, 12'd150,  8'h00, 2'b00},
        {2'd0, 12'd201,  8'h02, 2'b10},
        {2'd0, 12'd197,  8'h02, 2'b10},
        {2'd0, 12'd195,  8'h00, 2'b00},
        {2'd0, 12'd200,  8'h00, 2'b00},
        {2'd0, 12'd99,   8'h01, 2'b10},
        {2'd0, 12'd104,  8'h01, 2'b10},
        {2'd0, 12'd105,  8'h00, 2'b00},
        {2'd1, 12'd2001, 8'h08, 2'b10},
        {2'd1, 12'd1500, 8'h08, 2'b10},
        {2'd1, 12'd1000, 8'h08, 2'b10},
        {2'd1, 12'd999,  8'h00, 2'b00},
        {2'd3, 12'd4000, 8'h00, 2'b00},
        {2'd3, 12'd0,    8'h00, 2'b00},
        {2'd2, 12'd61,   8'h20, 2'b01},
        {2'd0, 12'd10,   8'h01, 2'b11},
        {2'd2, 12'd40,   8'h10, 2'b11},
        {2'd2, 12'd55,   8'h00, 2'b10},
        {2'd0, 12'd150,  8'h00, 2'b00},
        {2'd1, 12'd0,    8'h00, 2'b00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic meas(input logic [1:0] s, input logic [11:0] c);
        @(negedge clk);
        meas_valid = 1'b1; meas_sel = s; meas_code = c;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({safe1, safe2, alarm} == 3'b111, "R1 pins", {safe1, safe2, alarm}, 7);
        rd(4'd8, d);  check(d == 16'h0000, "R1 config", d, 0);
        rd(4'd1, d);  check(d == 16'h0FFF, "R1 high limit", d, 16'h0FFF);
        rd(4'd0, d);  check(d == 16'h0000, "R1 low limit", d, 0);
        rd(4'd10, d); check(d == 16'h0000, "R1 flags", d, 0);

        // R2 register map
        wr(4'd0, 16'd100);  wr(4'd1, 16'd200);
        wr(4'd2, 16'd1000); wr(4'd3, 16'd2000);
        wr(4'd4, 16'd50);   wr(4'd5, 16'd60);
        wr(4'd7, 16'h1234);
        rd(4'd3, d); check(d == 16'd2000, "R2 limit readback", d, 2000);
        rd(4'd5, d); check(d == 16'd60, "R2 limit readback", d, 60);
        rd(4'd7, d); check(d == 16'h0234, "R2 limit width", d, 16'h0234);
        wr(4'd8, 16'h0E37);
        rd(4'd8, d); check(d == 16'h0E37, "R2 config readback", d, 16'h0E37);

        // vector table: comparator mode, all outputs active-high
        for (int i = 0; i < NVEC; i++) begin
            meas(VEC[i][23:22], VEC[i][21:10]);
            check({safe1, safe2} == VEC[i][1:0], "R10/R3/R4/R5/R6 safe pins",
                  {safe1, safe2}, VEC[i][1:0]);
            check(alarm == (|VEC[i][1:0]), "R10 alarm OR", alarm, |VEC[i][1:0]);
            rd(4'd10, d);
            check(d == {8'h00, VEC[i][9:2]}, "R7/R3/R4/R5/R6 flags", d, VEC[i][9:2]);
        end

        // R12 polarity flip on an asserted output
        meas(2'd0, 12'd201);
        wr(4'd8, 16'h0C37);
        check(safe1 == 1'b0, "R12 safe1 active-low asserted", safe1, 0);
        check(alarm == 1'b1, "R12 alarm active-high asserted", alarm, 1);
        check(safe2 == 1'b0, "R12 safe2 active-high idle", safe2, 0);
        wr(4'd8, 16'h0E37);

        // R9 clear command drops live condition and flags
        check(safe1 == 1'b1, "R9 condition live before clear", safe1, 1);
        wr(4'd9, 16'h0001);
        check(safe1 == 1'b0, "R9 condition cleared", safe1, 0);
        rd(4'd10, d); check(d == 16'h0000, "R9 flags cleared", d, 0);

        // R11 interrupt mode holds until flag read
        wr(4'd8, 16'h0F37);
        meas(2'd0, 12'd201);
        check(safe1 == 1'b1, "R11 asserted on event", safe1, 1);
        meas(2'd0, 12'd150);
        check(safe1 == 1'b1, "R11 held after condition ends", safe1, 1);
        check(alarm == 1'b1, "R11 alarm held", alarm, 1);
        rd(4'd10, d); check(d == 16'h0002, "R11 flag contents", d, 2);
        check(safe1 == 1'b0, "R11 released by read", safe1, 0);

        // R8 read and event in the same cycle
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'd10;
        meas_valid = 1'b1; meas_sel = 2'd0; meas_code = 12'd99;
        @(negedge clk);
        reg_rd = 1'b0; meas_valid = 1'b0;
        check(reg_rdata == 16'h0000, "R8 read returns old flags", reg_rdata, 0);
        check(safe1 == 1'b1, "R8 flag kept, output asserted", safe1, 1);
        rd(4'd10, d); check(d == 16'h0001, "R8 new flag survived", d, 1);
        check(safe1 == 1'b0, "R11 released with condition still live", safe1, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule